// File: doc/BRIEF.md
# Stereo Digital Volume with Synchronised Update

This block scales a stereo stream of signed 24-bit audio samples by a separate digital gain on each side. Every channel is controlled by an 8-bit logarithmic gain code. Code zero silences the channel. Each step above zero adds 0.375 dB. Code C0h is unity gain. Everything from EFh upwards is held at the largest boost of about +17.6 dB. The product is rounded to nearest and clamped to the 24-bit range, so high gains cannot wrap.

Codes enter through a small register write port. A code written on its own only lands in a staging register. When a write has its update bit set, the staged codes of both channels are moved into the active gain registers on one clock edge, so left and right never run with mismatched settings. A two-state controller tracks whether staging and active codes agree. In `SYNCED`, staged equals active. A write without the update bit takes it to `PENDING`. A write with the update bit returns it to `SYNCED` from either state. The active gain is captured together with each sample, so each output sample carries exactly one gain. Samples leave two cycles after they arrive, with left and right aligned.

Top module: `stereo_volume`

## Requirements
- R1: After reset both staged codes and both active codes are C0h, `out_valid` is 0 and both output samples are 0.
- R2: A cycle with `reg_wr`=1 stores `reg_wdata[7:0]` into the staged code of the channel picked by `reg_sel` (0 = left, 1 = right). `reg_rdata` is combinational and returns `{1'b0, staged code of reg_sel}`, so bit 8 always reads 0.
- R3: A write with `reg_wdata[8]`=0 leaves both active gains unchanged, so later samples still use the previous gains.
- R4: A write with `reg_wdata[8]`=1 stages its own code and then copies both staged codes into the active registers at that same clock edge.
- R5: With active code 00h the channel outputs exactly 0.
- R6: For a nonzero code c, let e = min(c, 239), k = e / 16 and f = e mod 16. The gain is M[f]·2^(k−26), where M[f] = round(16384·2^(f/16)). Code C0h therefore passes samples through unchanged.
- R7: Codes EFh to FFh all give the same gain as EFh.
- R8: The scaled value is rounded to nearest with ties toward +infinity, then clamped to [−8388608, 8388607]. A non-negative input never yields a negative output.
- R9: A sample presented with `in_valid`=1 in cycle t appears with `out_valid`=1 in cycle t+2. Left and right stay aligned, and `out_valid` is 0 in cycles with no matching input.
- R10: The gain applied to a sample is the active gain in the cycle the sample is presented. A sample presented in the same cycle as a committing write uses the old gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Channel select for write and read (0 left, 1 right) |
| reg_wdata | input | 9 | Bit 8 update request, bits 7:0 gain code |
| reg_rdata | output | 9 | Staged code of the selected channel, bit 8 zero |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 24 | Left scaled sample, signed |
| out_right | output | 24 | Right scaled sample, signed |

## Verification
The hardest case to reach from the ports is a committing write that lands in the same cycle as an input sample, while the staged codes differ from the active ones. Only there can a wrong design apply the new gain one sample too early. The stimulus first stages a left code with a plain write. It then issues a committing write to the right channel while presenting a sample in the same cycle. The scoreboard expects the old gains on that sample and the new gains on both channels for the next one. The rounding-tie and clamp cases are reached by choosing a half-gain code with odd inputs and a top code with full-scale inputs.

// File: rtl/stvol_pkg.sv
package stvol_pkg;

    localparam int SAMPLE_W  = 24;
    localparam int CODE_W    = 8;
    localparam int MULT_W    = 16;
    localparam int MULT_FRAC = 14;
    localparam int SHIFT_W   = 5;

    typedef enum logic [0:0] {
        ST_SYNCED  = 1'b0,
        ST_PENDING = 1'b1
    } stage_state_e;

    typedef struct packed {
        logic               mute;
        logic [MULT_W-1:0]  mult;
        logic [SHIFT_W-1:0] shift;
    } gain_t;

    // Multiplier for one sixteenth of an octave, scaled by 2^MULT_FRAC.
    function automatic logic [MULT_W-1:0] frac_mult(input logic [3:0] f);
        logic [MULT_W-1:0] m;
        unique case (f)
            4'd0:  m = 16'd16384;
            4'd1:  m = 16'd17109;
            4'd2:  m = 16'd17867;
            4'd3:  m = 16'd18658;
            4'd4:  m = 16'd19484;
            4'd5:  m = 16'd20347;
            4'd6:  m = 16'd21247;
            4'd7:  m = 16'd22188;
            4'd8:  m = 16'd23170;
            4'd9:  m = 16'd24196;
            4'd10: m = 16'd25268;
            4'd11: m = 16'd26386;
            4'd12: m = 16'd27554;
            4'd13: m = 16'd28774;
            4'd14: m = 16'd30048;
            4'd15: m = 16'd31379;
            default: m = 16'd16384;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/stvol_regs.sv
module stvol_regs
    import stvol_pkg::*;
#(
    parameter int CW         = CODE_W,
    parameter int RESET_CODE = 192
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic                 sel,
    input  logic [CW:0]          wdata,
    output logic [CW:0]          rdata,
    output logic [1:0][CW-1:0]   act_codes
);

    localparam logic [CW-1:0] RST_VAL = CW'(RESET_CODE);

    stage_state_e        state_q, state_d;
    logic [1:0][CW-1:0]  stg_q, stg_d;
    logic [1:0][CW-1:0]  act_q;
    logic                wr_upd, wr_plain;
    logic                commit;

    assign wr_upd   = wr &&  wdata[CW];
    assign wr_plain = wr && !wdata[CW];

    always_comb begin
        stg_d = stg_q;
        if (wr) begin
            stg_d[sel] = wdata[CW-1:0];
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SYNCED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNCED:  if (wr_plain) state_d = ST_PENDING;
            ST_PENDING: if (wr_upd)   state_d = ST_SYNCED;
            default:    state_d = ST_SYNCED;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            ST_SYNCED:  commit = wr_upd;
            ST_PENDING: commit = wr_upd;
            default:    commit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= {2{RST_VAL}};
            act_q <= {2{RST_VAL}};
        end else begin
            stg_q <= stg_d;
            if (commit) begin
                act_q <= stg_d;
            end
        end
    end

    assign rdata     = {1'b0, stg_q[sel]};
    assign act_codes = act_q;

    p_hold_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_plain |=> $stable(act_q));

    p_commit_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_upd |=> (act_q == stg_q));

    p_synced_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNCED) |-> (act_q == stg_q));

endmodule

// File: rtl/stvol_gain_map.sv
module stvol_gain_map
    import stvol_pkg::*;
#(
    parameter int CW         = CODE_W,
    parameter int TOP_CODE   = 239,
    parameter int UNITY_CODE = 192
) (
    input  logic [CW-1:0] code,
    output gain_t         gain
);

    localparam int UNITY_OCT  = UNITY_CODE / 16;
    localparam int BASE_SHIFT = UNITY_OCT + MULT_FRAC;
    localparam logic [CW-1:0] TOP_VAL = CW'(TOP_CODE);

    logic [CW-1:0] eff;
    logic [CW-5:0] oct;
    logic [3:0]    frac;

    always_comb begin
        eff  = (code > TOP_VAL) ? TOP_VAL : code;
        oct  = eff[CW-1:4];
        frac = eff[3:0];
        gain.mute  = (code == '0);
        gain.mult  = frac_mult(frac);
        gain.shift = SHIFT_W'(BASE_SHIFT) - SHIFT_W'(oct);
    end

endmodule

// File: rtl/stvol_chan.sv
module stvol_chan
    import stvol_pkg::*;
#(
    parameter int DW = SAMPLE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    input  gain_t                gain,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_sample
);

    localparam int PW = DW + MULT_W + 1;
    localparam logic signed [PW-1:0] SAT_HI = PW'((64'sd1 <<< (DW - 1)) - 1);
    localparam logic signed [PW-1:0] SAT_LO = -SAT_HI - PW'(1);

    logic                 s1_valid;
    logic signed [DW-1:0] s1_x;
    gain_t                s1_g;

    logic signed [PW-1:0] prod, half, summed, scaled;
    logic signed [DW-1:0] clamped;

    // Stage 1: sample and the gain in force when it arrived
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_x     <= '0;
            s1_g     <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_x <= in_sample;
                s1_g <= gain;
            end
        end
    end

    always_comb begin
        prod   = PW'(s1_x) * $signed({1'b0, s1_g.mult});
        half   = PW'(1) <<< (s1_g.shift - SHIFT_W'(1));
        summed = prod + half;
        scaled = summed >>> s1_g.shift;
        if (s1_g.mute) begin
            clamped = '0;
        end else if (scaled > SAT_HI) begin
            clamped = SAT_HI[DW-1:0];
        end else if (scaled < SAT_LO) begin
            clamped = SAT_LO[DW-1:0];
        end else begin
            clamped = scaled[DW-1:0];
        end
    end

    // Stage 2: rounded, clamped result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_sample <= clamped;
            end
        end
    end

    p_mute_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_g.mute) |=> (out_sample == '0));

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_x[DW-1]) |=> !out_sample[DW-1]);

    p_neg_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_x[DW-1]) |=> (out_sample[DW-1] || out_sample == '0));

endmodule

// File: rtl/stereo_volume.sv
module stereo_volume
    import stvol_pkg::*;
#(
    parameter int DW         = SAMPLE_W,
    parameter int CW         = CODE_W,
    parameter int UNITY_CODE = 192,
    parameter int TOP_CODE   = 239
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [CW:0]          reg_wdata,
    output logic [CW:0]          reg_rdata,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_left,
    input  logic signed [DW-1:0] in_right,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_left,
    output logic signed [DW-1:0] out_right
);

    localparam int NCH = 2;

    logic [1:0][CW-1:0]   act_codes;
    logic signed [DW-1:0] ch_in  [NCH];
    logic signed [DW-1:0] ch_out [NCH];
    logic                 ch_vld [NCH];
    gain_t                ch_gain [NCH];

    assign ch_in[0] = in_left;
    assign ch_in[1] = in_right;

    stvol_regs #(
        .CW         (CW),
        .RESET_CODE (UNITY_CODE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .sel       (reg_sel),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .act_codes (act_codes)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        stvol_gain_map #(
            .CW         (CW),
            .TOP_CODE   (TOP_CODE),
            .UNITY_CODE (UNITY_CODE)
        ) u_map (
            .code (act_codes[ch]),
            .gain (ch_gain[ch])
        );

        stvol_chan #(
            .DW (DW)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (in_valid),
            .in_sample  (ch_in[ch]),
            .gain       (ch_gain[ch]),
            .out_valid  (ch_vld[ch]),
            .out_sample (ch_out[ch])
        );
    end

    assign out_valid = ch_vld[0];
    assign out_left  = ch_out[0];
    assign out_right = ch_out[1];

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    p_lr_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ch_vld[0] == ch_vld[1]);

endmodule

// File: tb/stereo_volume_test.sv
module stereo_volume_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n;
    logic               reg_wr, reg_sel;
    logic [8:0]         reg_wdata;
    logic [8:0]         reg_rdata;
    logic               in_valid;
    logic signed [23:0] in_left, in_right;
    logic               out_valid;
    logic signed [23:0] out_left, out_right;

    stereo_volume uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right)
    );

    typedef struct {
        int     l;
        int     r;
        longint stamp;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    int     n_checks = 0;
    int     n_fail   = 0;
    longint cycnt    = 0;
    bit     done     = 0;
    int     m_act_l  = 192, m_act_r = 192, m_stg_l = 192, m_stg_r = 192;

    always @(posedge clk) cycnt <= cycnt + 1;

    function automatic int ref_out(int code, int x);
        int     e, k, f, m, sh;
        longint p;
        if (code == 0) return 0;
        e  = (code > 239) ? 239 : code;
        k  = e / 16;
        f  = e % 16;
        m  = $rtoi(16384.0 * (2.0 ** (real'(f) / 16.0)) + 0.5);
        sh = 26 - k;
        p  = longint'(x) * longint'(m);
        p  = (p + (64'sd1 <<< (sh - 1))) >>> sh;
        if (p > 8388607)  p = 8388607;
        if (p < -8388608) p = -8388608;
        return int'(p);
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Driver: one cycle of stimulus, pushes expectation, then updates model
    task automatic step(bit v, int l, int r, bit wr, bit sel, bit upd, int code, string tag);
        @(negedge clk);
        in_valid  = v;
        in_left   = l[23:0];
        in_right  = r[23:0];
        reg_wr    = wr;
        reg_sel   = sel;
        reg_wdata = {upd, code[7:0]};
        if (v) sb.push_back('{ref_out(m_act_l, l), ref_out(m_act_r, r), cycnt, tag});
        if (wr) begin
            if (sel) m_stg_r = code & 255; else m_stg_l = code & 255;
            if (upd) begin
                m_act_l = m_stg_l;
                m_act_r = m_stg_r;
            end
        end
    endtask

    task automatic rd_check(bit sel, int exp, string req);
        @(negedge clk);
        in_valid = 1'b0;
        reg_wr   = 1'b0;
        reg_sel  = sel;
        #1;
        check(req, int'(reg_rdata), exp);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check("R9 unexpected out_valid", 1, 0);
            end else begin
                exp_t it;
                it = sb.pop_front();
                check({it.tag, " left"},  int'(out_left),  it.l);
                check({it.tag, " right"}, int'(out_right), it.r);
                check("R9 latency", int'(cycnt - it.stamp), 2);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
        in_valid = 0; in_left = '0; in_right = '0;
        repeat (3) @(negedge clk);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_left",  int'(out_left), 0);
        check("R1 out_right", int'(out_right), 0);
        reg_sel = 0; #1 check("R1 staged left", int'(reg_rdata), 192);
        reg_sel = 1; #1 check("R1 staged right", int'(reg_rdata), 192);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: unity passes samples unchanged, R9 back-to-back
        step(1, 1000, -1000, 0, 0, 0, 0, "R6 unity");
        step(1, 8388607, -8388608, 0, 0, 0, 0, "R6 unity fs");
        step(1, 0, 12345, 0, 0, 0, 0, "R6 unity");
        step(0, 0, 0, 0, 0, 0, 0, "idle");

        // R2/R3: plain write only stages
        step(0, 0, 0, 1, 0, 0, 'h90, "R2 write");
        rd_check(0, 'h90, "R2 readback left");
        rd_check(1, 192, "R2 readback right");
        step(1, 5000, -7000, 0, 0, 0, 0, "R3 gain held");
        step(0, 0, 0, 0, 0, 0, 0, "idle");

        // R4: committing write on the other channel commits both
        step(0, 0, 0, 1, 1, 1, 'hD0, "R4 commit");
        rd_check(1, 'hD0, "R2 update bit reads 0");
        step(1, 100000, 100000, 0, 0, 0, 0, "R4 both new");
        step(1, -77777, 4000000, 0, 0, 0, 0, "R4 both new");
        step(0, 0, 0, 0, 0, 0, 0, "idle");

        // R10: commit in same cycle as a sample
        step(0, 0, 0, 1, 0, 0, 'hB0, "R10 stage");
        step(1, 3, 3, 1, 1, 1, 'hB0, "R10 old gain");
        step(1, 3, 3, 0, 0, 0, 0, "R10 new gain");
        // R8 rounding ties at half gain
        step(1, 1, -1, 0, 0, 0, 0, "R8 round");
        step(1, -3, 5, 0, 0, 0, 0, "R8 round");
        step(0, 0, 0, 0, 0, 0, 0, "idle");

        // R5 mute
        step(0, 0, 0, 1, 0, 1, 0, "R5 commit mute");
        step(1, 8388607, 8388607, 0, 0, 0, 0, "R5 mute");
        step(1, -5, -5, 0, 0, 0, 0, "R5 mute");

        // R7 top region and R8 saturation
        step(0, 0, 0, 1, 0, 0, 'hEF, "R7 stage");
        step(0, 0, 0, 1, 1, 1, 'hFF, "R7 commit");
        step(1, 8388607, 8388607, 0, 0, 0, 0, "R8 sat high");
        step(1, -8388608, -8388608, 0, 0, 0, 0, "R8 sat low");
        step(1, 300000, 300000, 0, 0, 0, 0, "R7 top equal");
        step(1, -1000001, -1000001, 0, 0, 0, 0, "R7 top equal");

        // lowest nonzero code
        step(0, 0, 0, 1, 0, 0, 1, "R6 stage");
        step(0, 0, 0, 1, 1, 1, 2, "R6 commit");
        step(1, 8388607, -8388608, 0, 0, 0, 0, "R6 low code");

        // mixed patterns
        for (int i = 0; i < 300; i++) begin
            int  c  = int'($urandom_range(0, 255));
            bit  w  = ($urandom_range(0, 3) == 0);
            bit  s  = $urandom_range(0, 1) == 1;
            bit  u  = $urandom_range(0, 1) == 1;
            bit  v  = $urandom_range(0, 2) != 0;
            int  xl = int'($urandom_range(0, 16777215)) - 8388608;
            int  xr = int'($urandom_range(0, 16777215)) - 8388608;
            step(v, xl, xr, w, s, u, c, "R6 mixed");
        end

        repeat (4) step(0, 0, 0, 0, 0, 0, 0, "drain");
        check("R9 all outputs seen", sb.size(), 0);
        done = 1;
        summary();
    end

endmodule